// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Shift Register with Output Holding Stage

The block takes a serial bit stream on one pin and assembles it in a chain of eight stages, one stage per rising edge of its shift clock. A second, independent rising-edge clock copies the whole chain at once into a holding register. Only that holding register drives the parallel outputs, so the outputs stay steady while new data is being shifted in, and they update in a single step when the storage clock fires.

An active-low asynchronous clear empties the shift chain without touching the holding register. An active-low enable decides whether the parallel outputs drive the holding value or float at high impedance. The last stage of the chain also leaves the block on a serial output that the enable does not affect. Wiring that pin to the serial input of a second copy turns two blocks into one sixteen-stage register. If both clocks share the same edge, the holding register takes the chain content from just before that edge, so it runs one shift behind.

Top module: `serial_hold_reg`

## Requirements
- R1: On each rising edge of `shiftClk` while `clearN` is high, `serIn` enters stage 0 and stage i takes the old value of stage i-1. Stage i appears on `parOut[i]` after a store, so data moves from bit 0 toward bit 7.
- R2: On a rising edge of `storeClk` the holding register copies all eight stages. Between storage edges `parOut` does not change, whatever happens on `shiftClk`.
- R3: While `clearN` is low, every shift stage is 0 at once without a clock, and `shiftClk` edges have no effect. The holding register keeps its value until the next `storeClk` edge.
- R4: With `outEnN` high, all eight `parOut` bits are undriven (high impedance). With it low, they show the holding register.
- R5: `serOut` always equals the last shift stage (stage 7), whatever the value of `outEnN`.
- R6: When `shiftClk` and `storeClk` rise on the same edge, the holding register captures the chain content from before that edge.
- R7: When `serOut` of one block feeds `serIn` of a second block on shared clocks, the pair acts as a 16-stage register: after 16 shifts of a word sent most significant bit first, the second block holds the upper byte and the first block holds the lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftClk | input | 1 | Rising-edge clock of the shift chain |
| storeClk | input | 1 | Rising-edge clock of the holding register |
| clearN | input | 1 | Active-low asynchronous clear of the shift chain |
| serIn | input | 1 | Serial data into stage 0 |
| outEnN | input | 1 | Active-low enable of the parallel outputs |
| parOut | output | 8 | Holding register contents, or high impedance |
| serOut | output | 1 | Last shift stage, for cascading |

## Verification
The shift-chain properties sample on `shiftClk` and take it for granted that `clearN` changes only between shift edges, never at an edge itself. They also assume that any clear pulse spans at least one shift edge, because a pulse that starts and ends between two edges would not be seen in the sampled history. The bench keeps within this: it lowers `clearN` half a clock period before it pulses `shiftClk`, and raises it again only after that pulse is finished. It also changes `serIn` only while both clocks are low.

// File: rtl/serial_hold_pkg.sv
package serial_hold_pkg;

  // Strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic clearN;    // active-low chain clear
    logic shiftBit;  // bit entering stage 0
    logic driveEn;   // parallel outputs driven when 1
  } ctrlStrobes_t;

endpackage

// File: rtl/serial_hold_ctrl.sv
module serial_hold_ctrl
  import serial_hold_pkg::*;
(
  input  logic         clearN,
  input  logic         serIn,
  input  logic         outEnN,
  output ctrlStrobes_t ctl
);

  always_comb begin
    ctl.clearN   = clearN;
    ctl.shiftBit = serIn;
    ctl.driveEn  = ~outEnN;
  end

endmodule

// File: rtl/serial_hold_dp.sv
module serial_hold_dp
  import serial_hold_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              shiftClk,
  input  logic              storeClk,
  input  ctrlStrobes_t      ctl,
  output wire [STAGES-1:0]  parOut,
  output logic              serOut
);

  localparam int LAST = STAGES - 1;

  logic              clrN;
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] feed;
  logic [STAGES-1:0] hold;

  assign clrN = ctl.clearN;
  assign feed = {chain[LAST-1:0], ctl.shiftBit};

  // One flop per stage, each cleared asynchronously.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge shiftClk or negedge clrN) begin
      if (!clrN) chain[i] <= 1'b0;
      else       chain[i] <= feed[i];
    end
  end

  // Holding register: no clear, loads only on the storage clock.
  always_ff @(posedge storeClk) begin
    hold <= chain;
  end

  assign parOut = ctl.driveEn ? hold : {STAGES{1'bz}};
  assign serOut = chain[LAST];

  // R1: the bit sampled on serIn at one shift edge sits in stage 0 at the next.
  p_first_stage_r1: assert property (@(posedge shiftClk) disable iff (!clrN)
    $past(clrN) |-> chain[0] == $past(ctl.shiftBit));

  // R1: every later stage holds what its predecessor held one edge earlier.
  p_chain_move_r1: assert property (@(posedge shiftClk) disable iff (!clrN)
    $past(clrN) |-> chain[LAST:1] == $past(chain[LAST-1:0]));

  // R3: with the clear low at a shift edge the chain is already empty.
  p_clear_zero_r3: assert property (@(posedge shiftClk)
    !clrN |-> chain == '0);

  // R5: the serial output repeats the next-to-last stage one shift later.
  p_ser_out_r5: assert property (@(posedge shiftClk) disable iff (!clrN)
    $past(clrN) |-> serOut == $past(chain[LAST-1]));

endmodule

// File: rtl/serial_hold_reg.sv
module serial_hold_reg
  import serial_hold_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              shiftClk,
  input  logic              storeClk,
  input  logic              clearN,
  input  logic              serIn,
  input  logic              outEnN,
  output wire [STAGES-1:0]  parOut,
  output logic              serOut
);

  ctrlStrobes_t ctl;

  serial_hold_ctrl i_ctrl (
    .clearN (clearN),
    .serIn  (serIn),
    .outEnN (outEnN),
    .ctl    (ctl)
  );

  serial_hold_dp #(.STAGES(STAGES)) i_dp (
    .shiftClk (shiftClk),
    .storeClk (storeClk),
    .ctl      (ctl),
    .parOut   (parOut),
    .serOut   (serOut)
  );

endmodule

// File: tb/test_serial_hold_reg.sv
module test_serial_hold_reg;

  logic clk = 1'b0;
  logic shiftClk = 1'b0;
  logic storeClk = 1'b0;
  logic clearN = 1'b1;
  logic serIn = 1'b0;
  logic outEnN = 1'b0;
  wire  [7:0] busA;
  wire  [7:0] busB;
  logic serA;
  logic serB;
  int   checks = 0;
  int   errors = 0;
  int   ticks = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  // Pull-up on the first block's bus and pull-down on the second's make an
  // undriven bus visible as all ones or all zeros.
  for (genvar i = 0; i < 8; i++) begin : g_pull
    pullup   (busA[i]);
    pulldown (busB[i]);
  end

  serial_hold_reg i_serial_hold_reg (
    .shiftClk (shiftClk), .storeClk (storeClk), .clearN (clearN),
    .serIn (serIn), .outEnN (outEnN), .parOut (busA), .serOut (serA)
  );

  serial_hold_reg i_serial_hold_reg_b (
    .shiftClk (shiftClk), .storeClk (storeClk), .clearN (clearN),
    .serIn (serA), .outEnN (outEnN), .parOut (busB), .serOut (serB)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulseShift();
    #5 shiftClk = 1'b1;
    #5 shiftClk = 1'b0;
    #2;
  endtask

  task automatic pulseStore();
    #5 storeClk = 1'b1;
    #5 storeClk = 1'b0;
    #2;
  endtask

  task automatic pulseBoth();
    #5 begin shiftClk = 1'b1; storeClk = 1'b1; end
    #5 begin shiftClk = 1'b0; storeClk = 1'b0; end
    #2;
  endtask

  task automatic shiftByte(logic [7:0] d);
    for (int k = 7; k >= 0; k--) begin
      serIn = d[k];
      pulseShift();
    end
  endtask

  // Clear is held low across a shift edge carrying a 1.
  task automatic doClear();
    clearN = 1'b0;
    serIn  = 1'b1;
    #5;
    pulseShift();
    clearN = 1'b1;
    serIn  = 1'b0;
    #3;
  endtask

  task automatic t_reset();
    doClear();
    pulseStore();
    check("R3 cleared chain stored to bus", busA, 8'h00);
    check("R5 serOut after clear", {7'd0, serA}, 8'h00);
  endtask

  task automatic t_shift();
    shiftByte(8'hA5);
    check("R2 bus unchanged before store", busA, 8'h00);
    check("R5 serOut is stage 7", {7'd0, serA}, 8'h01);
    pulseStore();
    check("R1 byte A5 shifted in", busA, 8'hA5);
    serIn = 1'b0;
    pulseShift();
    check("R2 bus holds through shift", busA, 8'hA5);
    pulseStore();
    check("R1 one more shift toward bit 7", busA, 8'h4A);
  endtask

  task automatic t_clear();
    doClear();
    check("R3 clear leaves holding register", busA, 8'h4A);
    check("R3 serOut zero after clear", {7'd0, serA}, 8'h00);
    pulseStore();
    check("R3 chain empty despite shift edge", busA, 8'h00);
  endtask

  task automatic t_cascade_outen();
    logic [15:0] w;
    w = 16'hA55A;
    for (int k = 15; k >= 0; k--) begin
      serIn = w[k];
      pulseShift();
    end
    pulseStore();
    check("R7 lower byte in first block", busA, 8'h5A);
    check("R7 upper byte in second block", busB, 8'hA5);
    outEnN = 1'b1;
    #3;
    check("R4 first bus floats (pulled high)", busA, 8'hFF);
    check("R4 second bus floats (pulled low)", busB, 8'h00);
    check("R5 serOut A with outputs off", {7'd0, serA}, 8'h00);
    check("R5 serOut B with outputs off", {7'd0, serB}, 8'h01);
    outEnN = 1'b0;
    #3;
    check("R4 first bus driven again", busA, 8'h5A);
    check("R4 second bus driven again", busB, 8'hA5);
  endtask

  task automatic t_tied();
    doClear();
    pulseStore();
    shiftByte(8'h81);
    serIn = 1'b0;
    pulseBoth();
    check("R6 tied edge stores pre-edge chain", busA, 8'h81);
    pulseStore();
    check("R6 chain moved on tied edge", busA, 8'h02);
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 100000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", ticks, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #13;
    t_reset();
    t_shift();
    t_clear();
    t_cascade_outen();
    t_tied();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule